// File: doc/BRIEF.md
# UART Receive Byte Queue with Fill and Idle Interrupts

This block sits behind a UART deserializer and buffers the received bytes until software reads them. Each byte that the deserializer marks valid goes into a first-in first-out store. Each read strobe removes the oldest byte, and that byte is always visible on the head output. The current number of stored bytes is driven on an occupancy field. Software can therefore see a partly filled queue that has not yet raised an interrupt.

The block has two interrupt causes. The fill cause fires when the occupancy rises strictly above a programmable threshold. The threshold only moves the trigger point, so bytes that arrive between the interrupt and its service still find room. The idle cause fires when bytes are waiting and no new byte has arrived for a programmable number of byte-time ticks. This lets a short message that never reaches the threshold still be collected. A byte that arrives while the queue is full is lost, and a sticky overflow flag records the loss.

Configuration is held in a small register loaded by a strobe. Its reset values are parameters: by default a threshold of 100 in a 127-entry queue, an idle period of 2 ticks, and the idle cause enabled.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset the occupancy is 0 and all three flags are low. The configuration takes its parameter defaults (threshold DEF_THRESH, idle period DEF_TOUT, idle enable DEF_TOUT_EN) and holds them until `cfg_load_i` is sampled high.
- R2: `occ_o` (CNT_W bits, the number of stored bytes) rises by one on the clock edge that samples `rx_vld_i` high while the queue has room.
- R3: `fill_irq_o` goes high one cycle after the occupancy is strictly greater than the threshold. An occupancy equal to the threshold does not set it.
- R4: The queue stores DEPTH bytes whatever threshold is loaded.
- R5: `head_o` shows the oldest stored byte, and bytes leave in arrival order. A `rd_pop_i` sample removes exactly one byte. A pop on an empty queue changes nothing.
- R6: A byte offered while the queue is full and no pop is sampled is discarded: occupancy and head stay the same and `ovf_o` goes high.
- R7: A push and a pop sampled on the same edge leave the occupancy unchanged. This also holds when the queue is full, and then no overflow is flagged.
- R8: `ovf_o` stays high until a `clr_ovf_i` strobe is sampled.
- R9: The idle counter counts `tick_i` pulses. It restarts from zero on every accepted byte and is held at zero while the queue is empty. `idle_irq_o` goes high one cycle after the count reaches a nonzero idle period while the queue holds data and the idle enable is set.
- R10: With the idle enable clear, `idle_irq_o` is never set, however many ticks pass.
- R11: `fill_irq_o` and `idle_irq_o` are sticky. A clear strobe drops a flag on the next edge only if its condition no longer holds; otherwise the flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_vld_i | input | 1 | Received byte valid strobe |
| rx_byte_i | input | 8 | Received byte |
| rd_pop_i | input | 1 | Remove the head byte |
| tick_i | input | 1 | One pulse per byte time |
| cfg_load_i | input | 1 | Load the three configuration fields |
| cfg_thresh_i | input | CNT_W | Fill threshold |
| cfg_tout_i | input | TO_W | Idle period in ticks (0 disables) |
| cfg_tout_en_i | input | 1 | Idle interrupt enable |
| clr_fill_i | input | 1 | Clear fill flag |
| clr_idle_i | input | 1 | Clear idle flag |
| clr_ovf_i | input | 1 | Clear overflow flag |
| head_o | output | 8 | Oldest stored byte |
| occ_o | output | CNT_W | Occupancy |
| fill_irq_o | output | 1 | Fill interrupt flag |
| idle_irq_o | output | 1 | Idle interrupt flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
The bench builds the queue with DEPTH 8, a 4-bit idle counter, a default threshold of 5 and a default idle period of 3. With these values, filling the queue to capacity, pushing into a full queue, and a push with a pop on a full queue each take only a few cycles. The threshold boundary (5 stored bytes against 6) and the idle expiry after three ticks are also reached quickly. The non-power-of-two default depth of 127 uses the compare-based pointer wrap, which the small build does not exercise.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxq_cfg.sv
module rxq_cfg
    import rxq_pkg::*;
#(
    parameter int unsigned CNT_W       = 7,
    parameter int unsigned TO_W        = 8,
    parameter int unsigned DEF_THRESH  = 100,
    parameter int unsigned DEF_TOUT    = 2,
    parameter bit          DEF_TOUT_EN = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic [TO_W-1:0]  tout_i,
    input  logic             tout_en_i,
    output logic [CNT_W-1:0] thresh_o,
    output logic [TO_W-1:0]  tout_o,
    output logic             tout_en_o
);
    typedef struct packed {
        logic [CNT_W-1:0] thresh;
        logic [TO_W-1:0]  tout;
        logic             tout_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.thresh  = thresh_i;
            cfg_d.tout    = tout_i;
            cfg_d.tout_en = tout_en_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.thresh  <= CNT_W'(DEF_THRESH);
            cfg_q.tout    <= TO_W'(DEF_TOUT);
            cfg_q.tout_en <= DEF_TOUT_EN;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign thresh_o  = cfg_q.thresh;
    assign tout_o    = cfg_q.tout;
    assign tout_en_o = cfg_q.tout_en;

    AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(cfg_q)) else $error("config changed without load"); // R1
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 127,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1),
    parameter int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  byte_t            data_i,
    input  logic             pop_i,
    output byte_t            head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             push_ok_o,
    output logic             drop_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } st_t;

    st_t st_d, st_q;
    byte_t mem_q [DEPTH];

    logic full, empty, pop_ok, push_ok;
    logic [PTR_W-1:0] wr_inc, rd_inc;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
            assign wr_inc = st_q.wr_ptr + PTR_W'(1);
            assign rd_inc = st_q.rd_ptr + PTR_W'(1);
        end else begin : g_cmp_wrap
            assign wr_inc = (st_q.wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr_ptr + PTR_W'(1);
            assign rd_inc = (st_q.rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd_ptr + PTR_W'(1);
        end
    endgenerate

    always_comb begin
        full    = (st_q.count == CNT_W'(DEPTH));
        empty   = (st_q.count == '0);
        pop_ok  = pop_i & ~empty;
        push_ok = push_i & (~full | pop_ok);
        st_d    = st_q;
        if (push_ok) st_d.wr_ptr = wr_inc;
        if (pop_ok)  st_d.rd_ptr = rd_inc;
        unique case ({push_ok, pop_ok})
            2'b10:   st_d.count = st_q.count + CNT_W'(1);
            2'b01:   st_d.count = st_q.count - CNT_W'(1);
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (push_ok) mem_q[st_q.wr_ptr] <= data_i;
    end

    assign head_o    = mem_q[st_q.rd_ptr];
    assign count_o   = st_q.count;
    assign push_ok_o = push_ok;
    assign drop_o    = push_i & ~push_ok;

    AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.count <= CNT_W'(DEPTH)) else $error("count above depth"); // R4
    AST_POP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !empty && !push_i) |=> st_q.count == $past(st_q.count) - CNT_W'(1)) else $error("pop miscount"); // R5
    AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && full && !pop_i) |=> $stable(st_q.count) && $stable(st_q.wr_ptr)) else $error("full push stored"); // R6
    AST_PUSH_POP_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && pop_i && !empty) |=> $stable(st_q.count)) else $error("push+pop changed count"); // R7
endmodule

// File: rtl/rxq_idle.sv
module rxq_idle #(
    parameter int unsigned TO_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    input  logic            push_ok_i,
    input  logic            nonempty_i,
    input  logic [TO_W-1:0] tout_i,
    input  logic            tout_en_i,
    output logic            hit_o
);
    typedef struct packed {
        logic [TO_W-1:0] elapsed;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (push_ok_i || !nonempty_i) begin
            tmr_d.elapsed = '0;
        end else if (tick_i && (tmr_q.elapsed != '1)) begin
            tmr_d.elapsed = tmr_q.elapsed + TO_W'(1);
        end
        hit_o = tout_en_i & nonempty_i & (tout_i != '0) & (tmr_q.elapsed >= tout_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    AST_IDLE_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !nonempty_i |=> tmr_q.elapsed == '0) else $error("timer moved while empty"); // R9
    AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !push_ok_i && nonempty_i) |=> $stable(tmr_q.elapsed)) else $error("timer moved without tick"); // R9
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic             idle_hit_i,
    input  logic             drop_i,
    input  logic             clr_fill_i,
    input  logic             clr_idle_i,
    input  logic             clr_ovf_i,
    output logic             fill_o,
    output logic             idle_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic fill;
        logic idle;
        logic ovf;
    } flg_t;

    flg_t flg_d, flg_q;
    logic above;

    always_comb begin
        above      = (count_i > thresh_i);
        flg_d.fill = above      | (flg_q.fill & ~clr_fill_i);
        flg_d.idle = idle_hit_i | (flg_q.idle & ~clr_idle_i);
        flg_d.ovf  = drop_i     | (flg_q.ovf  & ~clr_ovf_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign fill_o = flg_q.fill;
    assign idle_o = flg_q.idle;
    assign ovf_o  = flg_q.ovf;

    AST_FILL_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_i > thresh_i) |=> flg_q.fill) else $error("fill flag missed"); // R3
    AST_IDLE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle_hit_i |=> flg_q.idle) else $error("idle flag missed"); // R9
    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flg_q.ovf && !clr_ovf_i) |=> flg_q.ovf) else $error("overflow flag lost"); // R8
    AST_FILL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flg_q.fill && !clr_fill_i) |=> flg_q.fill) else $error("fill flag lost"); // R11
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH       = 127,
    parameter int unsigned TO_W        = 8,
    parameter int unsigned DEF_THRESH  = 100,
    parameter int unsigned DEF_TOUT    = 2,
    parameter bit          DEF_TOUT_EN = 1'b1,
    localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rx_vld_i,
    input  logic [7:0]       rx_byte_i,
    input  logic             rd_pop_i,
    input  logic             tick_i,
    input  logic             cfg_load_i,
    input  logic [CNT_W-1:0] cfg_thresh_i,
    input  logic [TO_W-1:0]  cfg_tout_i,
    input  logic             cfg_tout_en_i,
    input  logic             clr_fill_i,
    input  logic             clr_idle_i,
    input  logic             clr_ovf_i,
    output logic [7:0]       head_o,
    output logic [CNT_W-1:0] occ_o,
    output logic             fill_irq_o,
    output logic             idle_irq_o,
    output logic             ovf_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0] thresh, count;
    logic [TO_W-1:0]  tout;
    logic             tout_en, push_ok, drop, idle_hit;
    byte_t            head;

    rxq_cfg #(
        .CNT_W(CNT_W), .TO_W(TO_W), .DEF_THRESH(DEF_THRESH),
        .DEF_TOUT(DEF_TOUT), .DEF_TOUT_EN(DEF_TOUT_EN)
    ) u_cfg (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cfg_load_i),
        .thresh_i(cfg_thresh_i), .tout_i(cfg_tout_i), .tout_en_i(cfg_tout_en_i),
        .thresh_o(thresh), .tout_o(tout), .tout_en_o(tout_en)
    );

    rxq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_store (
        .clk_i(clk_i), .rst_ni(rst_ni), .push_i(rx_vld_i), .data_i(rx_byte_i),
        .pop_i(rd_pop_i), .head_o(head), .count_o(count),
        .push_ok_o(push_ok), .drop_o(drop)
    );

    rxq_idle #(.TO_W(TO_W)) u_idle (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .push_ok_i(push_ok),
        .nonempty_i(count != '0), .tout_i(tout), .tout_en_i(tout_en), .hit_o(idle_hit)
    );

    rxq_irq #(.CNT_W(CNT_W)) u_irq (
        .clk_i(clk_i), .rst_ni(rst_ni), .count_i(count), .thresh_i(thresh),
        .idle_hit_i(idle_hit), .drop_i(drop), .clr_fill_i(clr_fill_i),
        .clr_idle_i(clr_idle_i), .clr_ovf_i(clr_ovf_i),
        .fill_o(fill_irq_o), .idle_o(idle_irq_o), .ovf_o(ovf_o)
    );

    assign head_o = head;
    assign occ_o  = count;

    AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tout_en && !idle_irq_o) |=> !idle_irq_o) else $error("idle set while disabled"); // R10
endmodule

// File: tb/rx_byte_queue_bench.sv
`timescale 1ns/1ps
module rx_byte_queue_bench;
    localparam int unsigned DEPTH = 8;
    localparam int unsigned CNT_W = 4;
    localparam int unsigned TO_W  = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_vld = 0, rd_pop = 0, tick = 0, cfg_load = 0, cfg_en = 0;
    logic clr_fill = 0, clr_idle = 0, clr_ovf = 0;
    logic [7:0] rx_byte = '0;
    logic [CNT_W-1:0] cfg_thr = '0;
    logic [TO_W-1:0] cfg_to = '0;
    logic [7:0] head;
    logic [CNT_W-1:0] occ;
    logic fill_irq, idle_irq, ovf;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rx_byte_queue #(.DEPTH(DEPTH), .TO_W(TO_W), .DEF_THRESH(5), .DEF_TOUT(3), .DEF_TOUT_EN(1'b1)) u_rx_byte_queue (
        .clk_i(clk), .rst_ni(rst_n), .rx_vld_i(rx_vld), .rx_byte_i(rx_byte),
        .rd_pop_i(rd_pop), .tick_i(tick), .cfg_load_i(cfg_load),
        .cfg_thresh_i(cfg_thr), .cfg_tout_i(cfg_to), .cfg_tout_en_i(cfg_en),
        .clr_fill_i(clr_fill), .clr_idle_i(clr_idle), .clr_ovf_i(clr_ovf),
        .head_o(head), .occ_o(occ), .fill_irq_o(fill_irq),
        .idle_irq_o(idle_irq), .ovf_o(ovf)
    );

    typedef struct packed {
        logic       push;
        logic [7:0] data;
        logic       pop;
        logic [3:0] cnt;
        logic [7:0] head;
        logic       hv;
    } vec_t;

    // R2 R5: push/pop sequence, expected occupancy and head after each edge
    localparam vec_t VEC [11] = '{
        '{1'b1, 8'hA1, 1'b0, 4'd1, 8'hA1, 1'b1},
        '{1'b1, 8'hB2, 1'b0, 4'd2, 8'hA1, 1'b1},
        '{1'b1, 8'hC3, 1'b1, 4'd2, 8'hB2, 1'b1},
        '{1'b0, 8'h00, 1'b1, 4'd1, 8'hC3, 1'b1},
        '{1'b1, 8'hD4, 1'b0, 4'd2, 8'hC3, 1'b1},
        '{1'b0, 8'h00, 1'b1, 4'd1, 8'hD4, 1'b1},
        '{1'b0, 8'h00, 1'b1, 4'd0, 8'h00, 1'b0},
        '{1'b0, 8'h00, 1'b1, 4'd0, 8'h00, 1'b0},
        '{1'b1, 8'hE5, 1'b0, 4'd1, 8'hE5, 1'b1},
        '{1'b1, 8'hF6, 1'b1, 4'd1, 8'hF6, 1'b1},
        '{1'b0, 8'h00, 1'b1, 4'd0, 8'h00, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        rx_vld = 0; rd_pop = 0; tick = 0; cfg_load = 0;
        clr_fill = 0; clr_idle = 0; clr_ovf = 0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_vld = 1; rx_byte = b; step();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin tick = 1; step(); end
    endtask

    task automatic load(input logic [CNT_W-1:0] t, input logic [TO_W-1:0] to, input logic en);
        cfg_thr = t; cfg_to = to; cfg_en = en; cfg_load = 1; step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        step();
        check("R1 occ", occ, 0);
        check("R1 flags", {fill_irq, idle_irq, ovf}, 0);

        foreach (VEC[i]) begin
            rx_vld = VEC[i].push; rx_byte = VEC[i].data; rd_pop = VEC[i].pop;
            step();
            check("R2 R5 occ", occ, VEC[i].cnt);
            if (VEC[i].hv) check("R5 head", head, VEC[i].head);
        end
        check("R5 flags quiet", {fill_irq, ovf}, 0);

        // R3 threshold default 5: equal does not fire, above does
        for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
        step();
        check("R3 equal occ", occ, 5);
        check("R3 equal no fill", fill_irq, 0);
        push(8'h15);
        step();
        check("R3 above fill", fill_irq, 1);
        push(8'h16); push(8'h17);
        check("R4 full occ", occ, 8);
        push(8'h99);
        check("R6 drop occ", occ, 8);
        check("R6 drop head", head, 8'h10);
        check("R6 ovf set", ovf, 1);
        step(); step(); step();
        check("R8 ovf sticky", ovf, 1);
        clr_fill = 1; step();
        check("R11 fill held", fill_irq, 1);
        clr_ovf = 1; step();
        check("R8 ovf cleared", ovf, 0);
        rx_vld = 1; rx_byte = 8'h50; rd_pop = 1; step();
        check("R7 full occ", occ, 8);
        check("R7 no ovf", ovf, 0);
        for (int i = 0; i < 8; i++) begin
            check("R5 order", head, (i < 7) ? 8'h11 + 8'(i) : 8'h50);
            rd_pop = 1; step();
        end
        check("R5 drained", occ, 0);
        clr_fill = 1; step();
        check("R11 fill cleared", fill_irq, 0);

        // R9 idle period 3 ticks
        load(5, 3, 1);
        push(8'hA0);
        ticks(2);
        check("R9 early", idle_irq, 0);
        push(8'hA1);
        ticks(2);
        check("R9 reload", idle_irq, 0);
        ticks(1);
        check("R9 edge", idle_irq, 0);
        step();
        check("R9 idle set", idle_irq, 1);
        clr_idle = 1; step();
        check("R11 idle held", idle_irq, 1);
        rd_pop = 1; step();
        rd_pop = 1; step();
        clr_idle = 1; step();
        check("R11 idle cleared", idle_irq, 0);

        // R10 enable clear
        load(5, 3, 0);
        push(8'hB0);
        ticks(5);
        step();
        check("R10 idle off", idle_irq, 0);
        rd_pop = 1; step();

        // R4 low threshold keeps full capacity
        load(1, 3, 0);
        for (int i = 0; i < 9; i++) push(8'h30 + 8'(i));
        check("R4 capacity", occ, 8);
        check("R4 fill", fill_irq, 1);
        check("R4 head", head, 8'h30);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule